// File: doc/BRIEF.md
# Configuration change protection unit

This block keeps system-critical registers and privileged memory instructions from being changed or run by accident. Software first writes a key byte to the block's key register. A valid key opens a short unlock window. During that window one protected register write, or one self-programming or fuse/signature-read instruction, is allowed. Each kind of unlock has its own key. Only one kind can be open at a time.

The window counts instruction-cycle ticks. Its count starts in the cycle after the key write. It closes once four ticks have been counted. It also closes at once on any memory write and on any SPM, LPM or SLEEP execution. The protected registers use `prot_commit` and `io_unlock`. The instruction decoder uses `spm_allow`, `lpm_allow` and `spm_unlock`. Software can read the active modes back on `mode_rd`.

Top module: `cfg_guard`

## Requirements
- R1: While reset is held and after it is released, both unlocks are low and `mode_rd` is 0.
- R2: A key write of 8'hD8 raises `io_unlock` from the next cycle on. A key write of 8'h9D raises `spm_unlock` from the next cycle on. `mode_rd` bit 0 reflects the I/O mode, bit 1 reflects the SPM mode, and all other bits read 0.
- R3: A key write of any other value closes both modes from the next cycle. A valid key write while the other mode is open switches to the new mode, so the two unlocks are never high together.
- R4: An open window lasts for exactly 4 instruction-cycle ticks counted after the key-write cycle. A tick in the key-write cycle does not count. Cycles without a tick do not shorten the window.
- R5: `prot_commit` is high only in a cycle with `prot_wr`, `prot_ce` and `io_unlock` all high. A protected write with `prot_ce` low is ignored.
- R6: A protected register write uses up the unlock. Both modes are closed from the next cycle, so a second write needs a new key.
- R7: A memory write (`mem_wr`), SLEEP, SPM or LPM in a cycle closes both modes from the next cycle.
- R8: `spm_allow` is high only when `exec_spm` is high and the SPM mode is open. The I/O mode never grants it.
- R9: An ordinary LPM (`lpm_special` low) always gets `lpm_allow`. An LPM that reads fuses or the signature row (`lpm_special` high) gets it only while the SPM mode is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_wr | input | 1 | CPU write to the key register |
| sig_data | input | 8 | Data of the key register write |
| instr_tick | input | 1 | One pulse per instruction cycle |
| mem_wr | input | 1 | Any other I/O or data memory write |
| prot_wr | input | 1 | Write to a protected register |
| prot_ce | input | 1 | Change-enable bit carried by that write |
| exec_spm | input | 1 | SPM instruction executing |
| exec_lpm | input | 1 | LPM instruction executing |
| lpm_special | input | 1 | LPM targets fuses or the signature row |
| exec_sleep | input | 1 | SLEEP instruction executing |
| io_unlock | output | 1 | Protected register writes are unlocked |
| spm_unlock | output | 1 | Privileged instructions are unlocked |
| prot_commit | output | 1 | The protected write in this cycle takes effect |
| spm_allow | output | 1 | The SPM in this cycle may run |
| lpm_allow | output | 1 | The LPM in this cycle may run |
| mode_rd | output | 8 | Read value of the active mode bits |

## Verification
On every cycle the assertions check the following properties:
- the two unlocks are mutually exclusive;
- a commit or a privileged grant never happens without its mode;
- ordinary LPM is always granted;
- any write, protected write or closing instruction leaves both modes shut in the next cycle;
- an invalid key leaves both modes shut in the next cycle;
- a window never closes in a cycle without a tick.

Some behaviours can only be shown by the bench's scenarios:
- the exact window length in ticks;
- that a tick in the key-write cycle is ignored;
- the switch from one mode to the other;
- the read-back encoding.

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int DW = 8,
  parameter int WINDOW = 4,
  parameter logic [DW-1:0] IO_SIG = 'hD8,
  parameter logic [DW-1:0] SPM_SIG = 'h9D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_wr,
  input  logic [DW-1:0] sig_data,
  input  logic          instr_tick,
  input  logic          mem_wr,
  input  logic          prot_wr,
  input  logic          prot_ce,
  input  logic          exec_spm,
  input  logic          exec_lpm,
  input  logic          lpm_special,
  input  logic          exec_sleep,
  output logic          io_unlock,
  output logic          spm_unlock,
  output logic          prot_commit,
  output logic          spm_allow,
  output logic          lpm_allow,
  output logic [DW-1:0] mode_rd
);
  localparam int CW = $clog2(WINDOW + 1);

  logic          io_q, spm_q;
  logic [CW-1:0] cnt_q;

  wire key_io  = sig_data == IO_SIG;
  wire key_spm = sig_data == SPM_SIG;
  wire close   = mem_wr | prot_wr | exec_spm | exec_lpm | exec_sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_q  <= 1'b0;
      spm_q <= 1'b0;
      cnt_q <= '0;
    end else if (sig_wr) begin
      io_q  <= key_io;
      spm_q <= key_spm;
      cnt_q <= (key_io | key_spm) ? CW'(WINDOW) : '0;
    end else if (close) begin
      io_q  <= 1'b0;
      spm_q <= 1'b0;
      cnt_q <= '0;
    end else if ((io_q | spm_q) && instr_tick) begin
      if (cnt_q <= CW'(1)) begin
        io_q  <= 1'b0;
        spm_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign io_unlock   = io_q;
  assign spm_unlock  = spm_q;
  assign prot_commit = prot_wr & prot_ce & io_q;
  assign spm_allow   = exec_spm & spm_q;
  assign lpm_allow   = exec_lpm & (~lpm_special | spm_q);
  assign mode_rd     = {{(DW-2){1'b0}}, spm_q, io_q};
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int DW = 8,
  parameter logic [DW-1:0] IO_SIG = 'hD8,
  parameter logic [DW-1:0] SPM_SIG = 'h9D
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sig_wr,
  input logic [DW-1:0] sig_data,
  input logic          instr_tick,
  input logic          mem_wr,
  input logic          prot_wr,
  input logic          prot_ce,
  input logic          exec_spm,
  input logic          exec_lpm,
  input logic          lpm_special,
  input logic          exec_sleep,
  input logic          io_unlock,
  input logic          spm_unlock,
  input logic          prot_commit,
  input logic          spm_allow,
  input logic          lpm_allow,
  input logic [DW-1:0] mode_rd
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (mode_rd == '0));

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_wr && sig_data != IO_SIG && sig_data != SPM_SIG) |=> (mode_rd == '0));

  // R3
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_unlock && spm_unlock));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_unlock && !instr_tick && !sig_wr && !mem_wr && !prot_wr && !exec_spm
     && !exec_lpm && !exec_sleep) |=> io_unlock);

  // R5
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_commit |-> (io_unlock && prot_ce && prot_wr));

  // R6
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && !sig_wr) |=> (!io_unlock && !spm_unlock));

  // R7
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || exec_sleep || exec_spm || exec_lpm) && !sig_wr) |=> (mode_rd == '0));

  // R8
  spm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spm_allow |-> (spm_unlock && exec_spm));

  // R9
  lpm_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_lpm && !lpm_special) |-> lpm_allow);
endmodule

bind cfg_guard cfg_guard_chk #(.DW(DW), .IO_SIG(IO_SIG), .SPM_SIG(SPM_SIG)) chk_i (.*);

// File: tb/cfg_guard_tb.sv
module cfg_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_wr = 1'b0;
  logic [7:0] sig_data = '0;
  logic instr_tick = 1'b0, mem_wr = 1'b0, prot_wr = 1'b0, prot_ce = 1'b0;
  logic exec_spm = 1'b0, exec_lpm = 1'b0, lpm_special = 1'b0, exec_sleep = 1'b0;
  logic io_unlock, spm_unlock, prot_commit, spm_allow, lpm_allow;
  logic [7:0] mode_rd;

  always #10 clk = ~clk;

  cfg_guard dut_i (.*);

  localparam int MW = 1, PW = 2, CE = 4, SPM = 8, LPM = 16, LSP = 32, SLP = 64, NOTICK = 128;
  // expected: {io_unlock, spm_unlock, prot_commit, spm_allow, lpm_allow, mode_rd[1:0]}
  localparam logic [6:0] E0 = 7'b0000000, EIO = 7'b1000001, ESP = 7'b0100010;
  localparam logic [6:0] CMT = 7'b0010000, SPA = 7'b0001000, LPA = 7'b0000100;

  logic [6:0] exp_q[$];
  string      tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic step(input logic sw, input logic [7:0] sd, input int ops,
                      input logic [6:0] exp, input string tag);
    @(negedge clk);
    sig_wr = sw; sig_data = sd;
    mem_wr = (ops & MW) != 0;  prot_wr = (ops & PW) != 0;  prot_ce = (ops & CE) != 0;
    exec_spm = (ops & SPM) != 0; exec_lpm = (ops & LPM) != 0;
    lpm_special = (ops & LSP) != 0; exec_sleep = (ops & SLP) != 0;
    instr_tick = (ops & NOTICK) == 0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic [6:0] exp, input string tag);
    step(1'b0, 8'h00, 0, exp, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [6:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {io_unlock, spm_unlock, prot_commit, spm_allow, lpm_allow, mode_rd[1:0]};
        checks++;
        if (a !== e || mode_rd[7:2] !== 6'b0) begin
          fails++;
          $display("FAIL %s: actual %b rd=%h expected %b", t, a, mode_rd, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(E0, "R1 in reset");
    idle(E0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(E0, "R1 after reset");
    // R2 R4 window length
    step(1'b1, 8'hD8, 0, E0, "R2 key cycle");
    for (int i = 0; i < 4; i++) idle(EIO, "R4 window open");
    idle(E0, "R4 window closed");
    // R5 R6 commit and consume
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    idle(EIO, "R2 io open");
    step(1'b0, 8'h00, PW | CE, EIO | CMT, "R5 commit");
    step(1'b0, 8'h00, PW | CE, E0, "R6 second write refused");
    // R5 change-enable low
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b0, 8'h00, PW, EIO, "R5 ce low ignored");
    idle(E0, "R6 consumed");
    // R7 memory write
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b0, 8'h00, MW, EIO, "R7 mem write");
    idle(E0, "R7 closed by write");
    // R4 ticks only
    step(1'b1, 8'hD8, 0, E0, "R4 key with tick");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, NOTICK, EIO, "R4 no tick holds");
    for (int i = 0; i < 4; i++) idle(EIO, "R4 counting ticks");
    idle(E0, "R4 closed after ticks");
    // R8 SPM
    step(1'b0, 8'h00, SPM, E0, "R8 spm locked");
    step(1'b1, 8'h9D, 0, E0, "R2 spm key");
    step(1'b0, 8'h00, SPM, ESP | SPA, "R8 spm granted");
    idle(E0, "R7 closed by spm");
    // R9 LPM
    step(1'b0, 8'h00, LPM, LPA, "R9 plain lpm");
    step(1'b0, 8'h00, LPM | LSP, E0, "R9 fuse lpm locked");
    step(1'b1, 8'h9D, 0, E0, "R2 spm key");
    step(1'b0, 8'h00, LPM | LSP, ESP | LPA, "R9 fuse lpm granted");
    idle(E0, "R7 closed by lpm");
    // R7 sleep and lpm
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b0, 8'h00, SLP, EIO, "R7 sleep");
    idle(E0, "R7 closed by sleep");
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b0, 8'h00, LPM, EIO | LPA, "R7 plain lpm");
    idle(E0, "R7 closed by plain lpm");
    // R3 bad key
    step(1'b1, 8'h55, 0, E0, "R3 bad key");
    idle(E0, "R3 nothing opened");
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b1, 8'h55, 0, EIO, "R3 bad key while open");
    idle(E0, "R3 closed by bad key");
    // R3 mode switch, R8 io mode grants nothing
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b1, 8'h9D, 0, EIO, "R3 switch key");
    step(1'b0, 8'h00, PW | CE, ESP, "R3 spm mode no commit");
    idle(E0, "R6 closed");
    step(1'b1, 8'hD8, 0, E0, "R2 key");
    step(1'b0, 8'h00, SPM, EIO, "R8 io mode no spm");
    idle(E0, "R7 closed");
    idle(E0, "R1 idle");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule